// File: doc/BRIEF.md
# Debug Integration Test Register Block

This block sits beside the debug logic of a processor core and lets test software take direct control of a few core pins for board-level integration checks and topology discovery. A single enable bit in a control register moves the block from functional mode into integration mode. In functional mode the three monitored core outputs simply carry the core's own signals. In integration mode those outputs instead carry values held in a write-only drive register, and a read-only sense register shows the live levels of four core inputs.

Software reaches the three registers through a simple APB-style register port (setup phase, then an enable phase in which the transfer completes with no wait states). The enable bit can only be set while the core reports that it is halted, and the two test registers respond only while the enable bit is set. After integration work the system is expected to be reset.

Top module: `dbg_itest_regs`

## Requirements
- R1: After reset the enable bit is 0, the drive register holds zero, and the three outputs carry the functional signals.
- R2: The control register at offset 0x00 reads back the enable in bit 0; all other bits read as zero whatever was written.
- R3: A write to 0x00 that sets bit 0 while `core_halted` is low leaves the enable bit at 0.
- R4: A write to 0x00 with bit 0 clear clears the enable bit whatever the level of `core_halted`.
- R5: While enabled, a write to 0x04 drives `pin_restarted` from bit 9, `pin_pmu_irq` from bit 4 and `pin_dbg_ack` from bit 0, from the clock edge that completes the write; other bits have no effect and the outputs hold until the next such write.
- R6: A read of 0x04 always returns zero.
- R7: While enabled, a read of 0x08 returns `pin_restart_req` in bit 11, `pin_fiq_n` in bit 2, `pin_irq_n` in bit 1, `pin_ext_dbg_req` in bit 0, as live levels, with all other bits zero.
- R8: While the enable bit is 0, writes to 0x04 do not change the drive register and reads of 0x08 return zero.
- R9: While the enable bit is 0, each output equals its functional input in the same cycle.
- R10: Reads of an unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Enable phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the enable phase |
| core_halted | input | 1 | Core is halted in debug state |
| func_restarted | input | 1 | Functional debug-restarted signal from the core |
| func_pmu_irq | input | 1 | Functional performance-monitor interrupt |
| func_dbg_ack | input | 1 | Functional debug acknowledge |
| pin_restarted | output | 1 | Debug-restarted output |
| pin_pmu_irq | output | 1 | Performance-monitor interrupt output |
| pin_dbg_ack | output | 1 | Debug acknowledge output |
| pin_restart_req | input | 1 | Debug restart request input |
| pin_irq_n | input | 1 | Active-low normal interrupt input |
| pin_fiq_n | input | 1 | Active-low fast interrupt input |
| pin_ext_dbg_req | input | 1 | External debug request input |

## Verification
A wrongly held enable bit shows at once on the outputs: in functional mode they must track the core signals in the same cycle, so a stuck enable makes a changed functional input fail to appear on the next sample, and the control register read exposes the bit directly. A corrupted drive register bit shows on its output one edge after the write, or, if corrupted while functional, on the first sample after integration mode is entered. Gating faults on the test registers appear on the first read of 0x08 or on outputs after a write that should have been ignored.

// File: rtl/dbg_itest_pkg.sv
package dbg_itest_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_CTRL  = 'h00;
  localparam int OFF_DRIVE = 'h04;
  localparam int OFF_SENSE = 'h08;
  localparam int ENABLE_BIT = 0;

  // drive slots: 0 debug ack, 1 pmu irq, 2 debug restarted
  localparam int OUT_N = 3;
  localparam int OUT_POS [OUT_N] = '{0, 4, 9};

  // sense slots: 0 ext dbg req, 1 irq_n, 2 fiq_n, 3 restart req
  localparam int IN_N = 4;
  localparam int IN_POS [IN_N] = '{0, 1, 2, 11};

  typedef struct packed {
    logic wr_ctrl;
    logic wr_drive;
    logic rd_ctrl;
    logic rd_sense;
  } acc_t;
endpackage

// File: rtl/itr_bus_decode.sv
module itr_bus_decode
  import dbg_itest_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output acc_t              acc
);
  logic hit_ctrl, hit_drive, hit_sense, wr_phase, rd_phase;

  always_comb begin
    hit_ctrl  = (paddr == ADDR_W'(OFF_CTRL));
    hit_drive = (paddr == ADDR_W'(OFF_DRIVE));
    hit_sense = (paddr == ADDR_W'(OFF_SENSE));
    wr_phase  = psel && penable && pwrite;
    rd_phase  = psel && !pwrite;
    acc.wr_ctrl  = wr_phase && hit_ctrl;
    acc.wr_drive = wr_phase && hit_drive;
    acc.rd_ctrl  = rd_phase && hit_ctrl;
    acc.rd_sense = rd_phase && hit_sense;
  end
endmodule

// File: rtl/itr_mode_ctrl.sv
module itr_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_enable_val,
  input  logic core_halted,
  output logic mode_q
);
  logic mode_d;

  always_comb begin
    mode_d = mode_q;
    if (wr_ctrl) begin
      if (!wr_enable_val)   mode_d = 1'b0;
      else if (core_halted) mode_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/itr_out_override.sv
module itr_out_override
  import dbg_itest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_q,
  input  logic              wr_drive,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OUT_N-1:0]  func_in,
  output logic [OUT_N-1:0]  pin_out
);
  logic [OUT_N-1:0] drive_q;

  for (genvar g = 0; g < OUT_N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  drive_q[g] <= 1'b0;
      else if (wr_drive && mode_q) drive_q[g] <= wdata[OUT_POS[g]];
    end
    assign pin_out[g] = mode_q ? drive_q[g] : func_in[g];
  end
endmodule

// File: rtl/dbg_itest_regs.sv
module dbg_itest_regs
  import dbg_itest_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              core_halted,
  input  logic              func_restarted,
  input  logic              func_pmu_irq,
  input  logic              func_dbg_ack,
  output logic              pin_restarted,
  output logic              pin_pmu_irq,
  output logic              pin_dbg_ack,
  input  logic              pin_restart_req,
  input  logic              pin_irq_n,
  input  logic              pin_fiq_n,
  input  logic              pin_ext_dbg_req
);
  acc_t             acc;
  logic             mode_q;
  logic [OUT_N-1:0] func_vec, pin_vec;
  logic [IN_N-1:0]  sense_vec;
  logic [31:0]      sense_word;

  itr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .acc(acc)
  );

  itr_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(acc.wr_ctrl),
    .wr_enable_val(pwdata[ENABLE_BIT]), .core_halted(core_halted),
    .mode_q(mode_q)
  );

  assign func_vec = {func_restarted, func_pmu_irq, func_dbg_ack};

  itr_out_override u_out (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .wr_drive(acc.wr_drive),
    .wdata(pwdata), .func_in(func_vec), .pin_out(pin_vec)
  );

  assign pin_dbg_ack   = pin_vec[0];
  assign pin_pmu_irq   = pin_vec[1];
  assign pin_restarted = pin_vec[2];

  assign sense_vec = {pin_restart_req, pin_fiq_n, pin_irq_n, pin_ext_dbg_req};

  always_comb begin
    sense_word = '0;
    for (int i = 0; i < IN_N; i++) sense_word[IN_POS[i]] = sense_vec[i];
  end

  always_comb begin
    prdata = '0;
    if (acc.rd_ctrl)               prdata[ENABLE_BIT] = mode_q;
    else if (acc.rd_sense && mode_q) prdata = sense_word;
  end
endmodule

// File: rtl/itr_checker.sv
module itr_checker #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              core_halted,
  input logic              mode,
  input logic              func_restarted,
  input logic              func_pmu_irq,
  input logic              func_dbg_ack,
  input logic              pin_restarted,
  input logic              pin_pmu_irq,
  input logic              pin_dbg_ack
);
  logic wr_c, wr_o, rd_o, rd_s;
  assign wr_c = psel && penable && pwrite && paddr == ADDR_W'(0);
  assign wr_o = psel && penable && pwrite && paddr == ADDR_W'(4);
  assign rd_o = psel && !pwrite && paddr == ADDR_W'(4);
  assign rd_s = psel && !pwrite && paddr == ADDR_W'(8);

  AST_FUNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode |-> (pin_dbg_ack == func_dbg_ack && pin_pmu_irq == func_pmu_irq && pin_restarted == func_restarted)); // R9
  AST_SET_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && pwdata[0] && !core_halted && !mode) |=> !mode); // R3
  AST_CLEAR_ANYTIME: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && !pwdata[0]) |=> !mode); // R4
  AST_DRIVE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && wr_o) |=> (pin_dbg_ack == $past(pwdata[0]) && pin_pmu_irq == $past(pwdata[4]) && pin_restarted == $past(pwdata[9]))); // R5
  AST_DRIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !wr_o) |=> (!mode || $stable({pin_restarted, pin_pmu_irq, pin_dbg_ack}))); // R5
  AST_DRIVE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |-> prdata == 32'd0); // R6
  AST_SENSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && !mode) |-> prdata == 32'd0); // R8
endmodule

bind dbg_itest_regs itr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .core_halted(core_halted),
  .mode(mode_q), .func_restarted(func_restarted), .func_pmu_irq(func_pmu_irq),
  .func_dbg_ack(func_dbg_ack), .pin_restarted(pin_restarted),
  .pin_pmu_irq(pin_pmu_irq), .pin_dbg_ack(pin_dbg_ack)
);

// File: tb/dbg_itest_regs_bench.sv
module dbg_itest_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic core_halted = 0;
  logic func_restarted = 0, func_pmu_irq = 0, func_dbg_ack = 0;
  logic pin_restarted, pin_pmu_irq, pin_dbg_ack;
  logic pin_restart_req = 0, pin_irq_n = 1, pin_fiq_n = 1, pin_ext_dbg_req = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_itest_regs u_dbg_itest_regs (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  function automatic logic [31:0] pins3();
    return {29'd0, pin_restarted, pin_pmu_irq, pin_dbg_ack};
  endfunction

  task automatic t_reset;
    logic [31:0] r;
    func_restarted = 1; func_pmu_irq = 0; func_dbg_ack = 1;
    #1 check("R1 outputs follow functional after reset", pins3(), 32'h5);
    bus_rd(4'h0, r);
    check("R1 enable clear after reset", r, 0);
  endtask

  task automatic t_func_follow;
    func_restarted = 0; func_pmu_irq = 1; func_dbg_ack = 0;
    #1 check("R9 functional pass-through", pins3(), 32'h2);
    func_restarted = 1; func_pmu_irq = 1; func_dbg_ack = 1;
    #1 check("R9 functional pass-through all high", pins3(), 32'h7);
  endtask

  task automatic t_gated;
    logic [31:0] r;
    bus_wr(4'h4, 32'h211);
    pin_restart_req = 1; pin_ext_dbg_req = 1;
    bus_rd(4'h8, r);
    check("R8 sense read zero while functional", r, 0);
    bus_rd(4'hC, r);
    check("R10 unmapped read zero", r, 0);
  endtask

  task automatic t_enter;
    logic [31:0] r;
    core_halted = 0;
    bus_wr(4'h0, 32'h1);
    bus_rd(4'h0, r);
    check("R3 set ignored when not halted", r, 0);
    core_halted = 1;
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, r);
    check("R2 enable set, reserved bits zero", r, 1);
    @(negedge clk);
    check("R8 earlier drive write ignored, R1 drive reset zero", pins3(), 0);
  endtask

  task automatic t_drive;
    logic [31:0] r;
    bus_wr(4'h4, 32'h0000_0211);
    check("R5 drive all three", pins3(), 32'h7);
    bus_wr(4'h4, 32'h0000_0010);
    check("R5 drive pmu only", pins3(), 32'h2);
    bus_wr(4'h4, 32'hFFFF_FDEE);
    check("R5 reserved bits no effect", pins3(), 32'h0);
    bus_wr(4'h4, 32'h0000_0201);
    func_restarted = 0; func_pmu_irq = 1; func_dbg_ack = 0;
    repeat (5) @(negedge clk);
    check("R5 drive held across idle cycles", pins3(), 32'h5);
    bus_rd(4'h4, r);
    check("R6 drive register reads zero", r, 0);
  endtask

  task automatic t_sense;
    logic [31:0] r;
    pin_restart_req = 1; pin_fiq_n = 0; pin_irq_n = 1; pin_ext_dbg_req = 0;
    bus_rd(4'h8, r);
    check("R7 sense pattern A", r, 32'h802);
    pin_restart_req = 0; pin_fiq_n = 1; pin_irq_n = 0; pin_ext_dbg_req = 1;
    bus_rd(4'h8, r);
    check("R7 sense pattern B", r, 32'h005);
    bus_rd(4'hC, r);
    check("R10 unmapped read zero in mode", r, 0);
  endtask

  task automatic t_clear;
    logic [31:0] r;
    core_halted = 0;
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h0, r);
    check("R4 clear while not halted", r, 0);
    func_restarted = 0; func_pmu_irq = 1; func_dbg_ack = 1;
    #1 check("R9 outputs back to functional", pins3(), 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_func_follow;
    t_gated;
    t_enter;
    t_drive;
    t_sense;
    t_clear;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule